// File: doc/BRIEF.md
# Sampling Converter Control Interface

This block is the digital half of a 14-bit sampling converter. A host bus starts a conversion with an active-low strobe and then reads the result back as two bytes over an eight-bit bus. A status line shows whether a conversion is in progress. A mode strap chooses how the start strobe and the status line depend on chip select. A polarity strap chooses straight binary or twos complement coding. A fixed cycle count stands in for the analog conversion time. The raw value to be converted arrives on an input port, and the block samples it when the conversion starts.

At the chip pads, the data bus and the status line are tri-stated. The block therefore gives each of them a value output and a separate drive-enable output. The status line is a driven signal in synchronous mode and behaves as an open-drain signal in asynchronous mode. After reset, the block accepts no start request until a hold-off interval has passed.

Top module: `conv_iface`

## Requirements
- R1: For RST_HOLD clock cycles after reset is released, a falling edge on `sc_n` starts no conversion. Once that interval has passed, starts are accepted.
- R2: With `sync_mode` = 1, a falling edge on `sc_n` starts a conversion only if `cs_n` is low when the edge is sampled.
- R3: With `sync_mode` = 0, a falling edge on `sc_n` starts a conversion whatever the level of `cs_n`.
- R4: A start is accepted only if `sc_n` is sampled low on MIN_PW consecutive clock edges, counting the edge that detects the fall. A shorter low pulse is discarded.
- R5: An accepted conversion keeps the block busy for exactly CONV_CYC clock cycles. The block captures `code_in` in the cycle the start is accepted, so later changes to `code_in` do not affect that conversion.
- R6: A falling edge on `sc_n` during a conversion is discarded. Holding `sc_n` low through and past the end of a conversion starts no further conversion; a new falling edge is needed.
- R7: With `sync_mode` = 1, `eoc_oe` is 1 exactly when `cs_n` and `eoc_en_n` are both low. While it is 1, `eoc_out` is 0 during a conversion and 1 otherwise.
- R8: With `sync_mode` = 0, `eoc_oe` is 1 only when `eoc_en_n` is low and a conversion is in progress, and `eoc_out` is always 0. The line is released whenever no conversion is running.
- R9: `db_oe` is 1 only when `cs_n` and `oe_n` are both low. Whenever `db_oe` is 0, `db_out` is 0.
- R10: The result forms a 16-bit word: the 14 result bits sit at the top (bits 15 to 2) and bits 1 and 0 are zero. With `byte_sel` = 0 the bus carries word bits 15..8, which are result bits 13..6. With `byte_sel` = 1 it carries word bits 7..0, which are result bits 5..0 followed by two zeros.
- R11: With `bipolar` = 0 the result equals the captured code (straight binary). With `bipolar` = 1 the result is the captured code with bit 13 inverted (twos complement), so mid-scale 0x2000 reads as 0x0000.
- R12: The readable result changes only when a conversion completes. A read during a conversion returns the previous result, and the result is zero after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| sc_n | input | 1 | Start-convert strobe, active low |
| oe_n | input | 1 | Data read enable, active low |
| eoc_en_n | input | 1 | Status line enable, active low |
| byte_sel | input | 1 | 0 selects the high byte, 1 selects the low byte |
| sync_mode | input | 1 | Strap: 1 synchronous, 0 asynchronous gating |
| bipolar | input | 1 | Strap: 1 twos complement, 0 straight binary |
| code_in | input | 14 | Raw code standing in for the analog input |
| db_out | output | 8 | Data bus value |
| db_oe | output | 1 | Data bus drive enable |
| eoc_out | output | 1 | Status line value (high = idle) |
| eoc_oe | output | 1 | Status line drive enable |

## Verification
The main conversion-and-read path is swept over 68 codes. These mix a strided spread across the full range with the values at zero, at the midpoint, just below the midpoint and at full scale. The sweep runs under every combination of the mode strap and the polarity strap. The midpoint and full-scale codes show whether the top bit is inverted in the right mode. The strided codes show whether any bit lands in the wrong byte or the wrong position.

Separate patterns cover the other cases:
- a start pulse one cycle too short;
- a start attempted with chip select high in each mode;
- a second strobe during a busy period;
- a strobe held low past the end of a conversion;
- an input change just after the start is accepted.

Together these separate correct gating from starts that are late, lost or repeated.

// File: rtl/conv_pkg.sv
`timescale 1ns/1ps
package conv_pkg;
    localparam int CODE_W = 14;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int PAD_W  = WORD_W - CODE_W;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [BYTE_W-1:0] byte_t;

    // Twos complement is straight binary with the top bit flipped.
    function automatic code_t encode_code(input code_t raw, input logic bip);
        code_t c;
        c = raw;
        c[CODE_W-1] = raw[CODE_W-1] ^ bip;
        return c;
    endfunction

    // Left-justify the code in a word, then choose one half of it.
    function automatic byte_t pick_byte(input code_t v, input logic lo_sel);
        logic [WORD_W-1:0] w;
        w = {v, {PAD_W{1'b0}}};
        return lo_sel ? w[BYTE_W-1:0] : w[WORD_W-1:BYTE_W];
    endfunction
endpackage

// File: rtl/conv_start_gate.sv
`timescale 1ns/1ps
module conv_start_gate #(
    parameter int RST_HOLD = 2500,
    parameter int MIN_PW   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sc_n,
    input  logic sync_mode,
    input  logic busy_i,
    output logic start_o
);
    localparam int PW_W = $clog2(MIN_PW + 1);
    localparam int HO_W = $clog2(RST_HOLD + 1);

    typedef struct packed {
        logic            sc_prev;
        logic            armed;
        logic [PW_W-1:0] low_cnt;
        logic [HO_W-1:0] hold_cnt;
    } gate_t;

    gate_t st_q, st_d;
    logic  fall, ready, gate_ok, start;

    always_comb begin
        st_d    = st_q;
        fall    = st_q.sc_prev & ~sc_n;
        ready   = (st_q.hold_cnt == HO_W'(RST_HOLD));
        gate_ok = sync_mode ? ~cs_n : 1'b1;
        start   = st_q.armed & ~sc_n & (st_q.low_cnt == PW_W'(MIN_PW - 1));

        st_d.sc_prev = sc_n;
        if (!ready) st_d.hold_cnt = st_q.hold_cnt + 1'b1;

        if (sc_n) begin
            st_d.armed   = 1'b0;
            st_d.low_cnt = '0;
        end else if (fall) begin
            st_d.armed   = gate_ok & ready & ~busy_i;
            st_d.low_cnt = PW_W'(1);
        end else if (start) begin
            st_d.armed   = 1'b0;
        end else if (st_q.armed) begin
            st_d.low_cnt = st_q.low_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.sc_prev  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign start_o = start;
endmodule

// File: rtl/conv_engine.sv
`timescale 1ns/1ps
module conv_engine
    import conv_pkg::*;
#(
    parameter int CONV_CYC = 1575
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start_i,
    input  logic  bipolar_i,
    input  code_t code_i,
    output logic  busy_o,
    output code_t result_o
);
    localparam int CNT_W = $clog2(CONV_CYC);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        code_t            held;
        code_t            result;
    } eng_t;

    eng_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (cur_q.busy) begin
            if (cur_q.cnt == '0) begin
                nxt_d.busy   = 1'b0;
                nxt_d.result = cur_q.held;
            end else begin
                nxt_d.cnt = cur_q.cnt - 1'b1;
            end
        end else if (start_i) begin
            nxt_d.busy = 1'b1;
            nxt_d.cnt  = CNT_W'(CONV_CYC - 1);
            nxt_d.held = encode_code(code_i, bipolar_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign busy_o   = cur_q.busy;
    assign result_o = cur_q.result;
endmodule

// File: rtl/conv_out_drive.sv
`timescale 1ns/1ps
module conv_out_drive
    import conv_pkg::*;
(
    input  logic  cs_n,
    input  logic  oe_n,
    input  logic  eoc_en_n,
    input  logic  byte_sel,
    input  logic  sync_mode,
    input  logic  busy_i,
    input  code_t result_i,
    output byte_t db_val,
    output logic  db_en,
    output logic  eoc_val,
    output logic  eoc_en
);
    always_comb begin
        db_en  = ~cs_n & ~oe_n;
        db_val = db_en ? pick_byte(result_i, byte_sel) : '0;
        if (sync_mode) begin
            eoc_en  = ~cs_n & ~eoc_en_n;
            eoc_val = eoc_en & ~busy_i;
        end else begin
            eoc_en  = ~eoc_en_n & busy_i;
            eoc_val = 1'b0;
        end
    end
endmodule

// File: rtl/conv_iface.sv
`timescale 1ns/1ps
module conv_iface #(
    parameter int RST_HOLD = 2500,
    parameter int MIN_PW   = 3,
    parameter int CONV_CYC = 1575
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cs_n,
    input  logic                          sc_n,
    input  logic                          oe_n,
    input  logic                          eoc_en_n,
    input  logic                          byte_sel,
    input  logic                          sync_mode,
    input  logic                          bipolar,
    input  logic [conv_pkg::CODE_W-1:0]   code_in,
    output logic [conv_pkg::BYTE_W-1:0]   db_out,
    output logic                          db_oe,
    output logic                          eoc_out,
    output logic                          eoc_oe
);
    logic                        start;
    logic                        busy;
    logic [conv_pkg::CODE_W-1:0] result;

    conv_start_gate #(.RST_HOLD(RST_HOLD), .MIN_PW(MIN_PW)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sc_n      (sc_n),
        .sync_mode (sync_mode),
        .busy_i    (busy),
        .start_o   (start)
    );

    conv_engine #(.CONV_CYC(CONV_CYC)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .bipolar_i (bipolar),
        .code_i    (code_in),
        .busy_o    (busy),
        .result_o  (result)
    );

    conv_out_drive u_drv (
        .cs_n      (cs_n),
        .oe_n      (oe_n),
        .eoc_en_n  (eoc_en_n),
        .byte_sel  (byte_sel),
        .sync_mode (sync_mode),
        .busy_i    (busy),
        .result_i  (result),
        .db_val    (db_out),
        .db_en     (db_oe),
        .eoc_val   (eoc_out),
        .eoc_en    (eoc_oe)
    );
endmodule

// File: rtl/conv_iface_chk.sv
`timescale 1ns/1ps
module conv_iface_chk #(
    parameter int RST_HOLD = 2500,
    parameter int CONV_CYC = 1575
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cs_n,
    input logic        sc_n,
    input logic        oe_n,
    input logic        eoc_en_n,
    input logic        sync_mode,
    input logic        busy,
    input logic [7:0]  db_out,
    input logic        db_oe,
    input logic        eoc_out,
    input logic        eoc_oe,
    input logic [13:0] result
);
    int since_q;
    int run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= 0;
            run_q   <= 0;
        end else begin
            if (since_q <= RST_HOLD) since_q <= since_q + 1;
            run_q <= busy ? run_q + 1 : 0;
        end
    end

    // R1
    holdoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (since_q > RST_HOLD));

    // R5
    conv_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == CONV_CYC));

    // R6
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(sc_n));

    // R7
    eoc_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode && !cs_n && !eoc_en_n) |-> (eoc_oe && (eoc_out == !busy)));

    // R8
    eoc_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_mode && eoc_oe) |-> (!eoc_out && busy));

    // R9
    bus_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || oe_n) |-> (!db_oe && db_out == 8'h00));

    // R12
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $stable(result));
endmodule

bind conv_iface conv_iface_chk #(.RST_HOLD(RST_HOLD), .CONV_CYC(CONV_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .sc_n      (sc_n),
    .oe_n      (oe_n),
    .eoc_en_n  (eoc_en_n),
    .sync_mode (sync_mode),
    .busy      (busy),
    .db_out    (db_out),
    .db_oe     (db_oe),
    .eoc_out   (eoc_out),
    .eoc_oe    (eoc_oe),
    .result    (result)
);

// File: tb/test_conv_iface.sv
`timescale 1ns/1ps
module test_conv_iface;
    localparam int RH = 20;
    localparam int PW = 3;
    localparam int CC = 12;

    logic        clk = 1'b0;
    logic        rst_n, cs_n, sc_n, oe_n, eoc_en_n, byte_sel, sync_mode, bipolar;
    logic [13:0] code_in;
    logic [7:0]  db_out;
    logic        db_oe, eoc_out, eoc_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    conv_iface #(.RST_HOLD(RH), .MIN_PW(PW), .CONV_CYC(CC)) i_conv_iface (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sc_n(sc_n), .oe_n(oe_n),
        .eoc_en_n(eoc_en_n), .byte_sel(byte_sel), .sync_mode(sync_mode),
        .bipolar(bipolar), .code_in(code_in), .db_out(db_out), .db_oe(db_oe),
        .eoc_out(eoc_out), .eoc_oe(eoc_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic pulse(input int n);
        sc_n = 1'b0;
        repeat (n) @(negedge clk);
        sc_n = 1'b1;
    endtask

    task automatic measure(output int len);
        len = 0;
        #1;
        while (eoc_oe && !eoc_out && len < 200) begin
            len++;
            @(negedge clk);
            #1;
        end
    endtask

    task automatic convert(input logic [13:0] code, input logic bip,
                           input logic sm, output int len);
        code_in = code; bipolar = bip; sync_mode = sm;
        cs_n = 1'b0; eoc_en_n = 1'b0; oe_n = 1'b1;
        @(negedge clk);
        pulse(PW);
        measure(len);
    endtask

    task automatic read_word(output logic [7:0] hi, output logic [7:0] lo);
        @(negedge clk);
        cs_n = 1'b0; oe_n = 1'b0; byte_sel = 1'b0;
        #1 hi = db_out;
        @(negedge clk);
        byte_sel = 1'b1;
        #1 lo = db_out;
        oe_n = 1'b1; byte_sel = 1'b0;
    endtask

    function automatic logic [13:0] expect_code(input logic [13:0] c, input logic bip);
        return bip ? (c ^ 14'h2000) : c;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R5 actual=%0d expected=%0d", 0, 1);
            report();
        end
    end

    initial begin
        int          len;
        logic [7:0]  hi, lo;
        logic [13:0] e, prev;

        rst_n = 1'b0; cs_n = 1'b1; sc_n = 1'b1; oe_n = 1'b1; eoc_en_n = 1'b1;
        byte_sel = 1'b0; sync_mode = 1'b1; bipolar = 1'b0; code_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state: idle status, bus undriven, result zero
        cs_n = 1'b0; eoc_en_n = 1'b0;
        #1;
        chk(eoc_oe && eoc_out, "R7 idle status after reset", {eoc_oe, eoc_out}, 3);
        chk(!db_oe && db_out == 0, "R9 bus off after reset", {db_oe, db_out}, 0);

        // R1: start during hold-off is ignored
        @(negedge clk);
        code_in = 14'h0AAA;
        pulse(PW);
        #1 chk(eoc_out == 1'b1, "R1 start in hold-off", eoc_out, 1);
        repeat (4) @(negedge clk);
        #1 chk(eoc_out == 1'b1, "R1 still idle", eoc_out, 1);
        read_word(hi, lo);
        chk(hi == 0 && lo == 0, "R12 result zero after reset", {hi, lo}, 0);
        repeat (RH + 5) @(negedge clk);
        convert(14'h0AAA, 1'b0, 1'b1, len);
        chk(len == CC, "R1 start accepted after hold-off", len, CC);

        // Sweep across straps and codes
        for (int sm = 0; sm < 2; sm++) begin
            for (int bp = 0; bp < 2; bp++) begin
                for (int i = 0; i < 68; i++) begin
                    logic [13:0] c;
                    case (i)
                        64:      c = 14'h0000;
                        65:      c = 14'h1FFF;
                        66:      c = 14'h2000;
                        67:      c = 14'h3FFF;
                        default: c = 14'((i * 263 + 5) & 16'h3FFF);
                    endcase
                    convert(c, bp[0], sm[0], len);
                    chk(len == CC, "R5 conversion length", len, CC);
                    read_word(hi, lo);
                    e = expect_code(c, bp[0]);
                    chk(hi == e[13:6], bp[0] ? "R11 high byte" : "R10 high byte", hi, e[13:6]);
                    chk(lo == {e[5:0], 2'b00}, bp[0] ? "R11 low byte" : "R10 low byte", lo, {e[5:0], 2'b00});
                end
            end
        end

        // R12 and R5 capture: read during conversion, change input after start
        convert(14'h1234, 1'b0, 1'b1, len);
        prev = 14'h1234;
        code_in = 14'h0F0F;
        @(negedge clk);
        pulse(PW);
        code_in = 14'h3FFF;
        oe_n = 1'b0; byte_sel = 1'b0;
        #1;
        chk(eoc_out == 1'b0, "R12 conversion running", eoc_out, 0);
        chk(db_out == prev[13:6], "R12 read during conversion", db_out, prev[13:6]);
        oe_n = 1'b1;
        measure(len);
        read_word(hi, lo);
        chk(hi == 8'h3C && lo == 8'h3C, "R5 captured at start", {hi, lo}, 16'h3C3C);

        // R4: pulse one cycle short is discarded
        sync_mode = 1'b1; cs_n = 1'b0; eoc_en_n = 1'b0;
        @(negedge clk);
        pulse(PW - 1);
        #1 chk(eoc_out == 1'b1, "R4 short pulse", eoc_out, 1);
        repeat (3) @(negedge clk);
        #1 chk(eoc_out == 1'b1, "R4 short pulse later", eoc_out, 1);

        // R6: strobe during busy ignored
        @(negedge clk);
        pulse(PW);
        repeat (2) @(negedge clk);
        pulse(PW);
        measure(len);
        chk(len == CC - 2 - PW, "R6 busy strobe ignored", len, CC - 2 - PW);
        repeat (6) @(negedge clk);
        #1 chk(eoc_out == 1'b1, "R6 no second conversion", eoc_out, 1);

        // R6: held-low strobe does not retrigger
        @(negedge clk);
        sc_n = 1'b0;
        repeat (PW) @(negedge clk);
        measure(len);
        chk(len == CC, "R6 held low single conversion", len, CC);
        repeat (10) @(negedge clk);
        #1 chk(eoc_out == 1'b1, "R6 held low no retrigger", eoc_out, 1);
        sc_n = 1'b1;

        // R2: sync mode with chip select high
        @(negedge clk);
        cs_n = 1'b1;
        pulse(PW);
        #1 chk(eoc_oe == 1'b0, "R7 status off with cs high", eoc_oe, 0);
        @(negedge clk);
        cs_n = 1'b0;
        #1 chk(eoc_oe && eoc_out, "R2 no start with cs high", {eoc_oe, eoc_out}, 3);
        @(negedge clk);
        eoc_en_n = 1'b1;
        #1 chk(eoc_oe == 1'b0, "R7 status off with enable high", eoc_oe, 0);
        eoc_en_n = 1'b0;

        // R3 and R8: async mode ignores chip select
        @(negedge clk);
        sync_mode = 1'b0; cs_n = 1'b1; eoc_en_n = 1'b0;
        #1 chk(eoc_oe == 1'b0, "R8 released when idle", eoc_oe, 0);
        @(negedge clk);
        pulse(PW);
        #1 chk(eoc_oe && !eoc_out, "R3 start with cs high", {eoc_oe, eoc_out}, 2);
        @(negedge clk);
        eoc_en_n = 1'b1;
        #1 chk(eoc_oe == 1'b0, "R8 enable high releases", eoc_oe, 0);
        eoc_en_n = 1'b0;
        measure(len);
        chk(eoc_oe == 1'b0, "R8 released after conversion", eoc_oe, 0);

        // R9: bus enable gating
        @(negedge clk);
        cs_n = 1'b0; oe_n = 1'b1;
        #1 chk(!db_oe && db_out == 0, "R9 oe high", {db_oe, db_out}, 0);
        @(negedge clk);
        cs_n = 1'b1; oe_n = 1'b0;
        #1 chk(!db_oe && db_out == 0, "R9 cs high", {db_oe, db_out}, 0);
        @(negedge clk);
        cs_n = 1'b0;
        #1 chk(db_oe == 1'b1, "R9 both low drives", db_oe, 1);
        oe_n = 1'b1;

        done = 1'b1;
        report();
    end
endmodule